// File: doc/BRIEF.md
# Mesh Synthetic Traffic Pattern Generator

This block is the traffic source for one node of a two-dimensional mesh. Each cycle it may decide to offer a packet, and it turns each decision into a descriptor: the node's own coordinates, a destination, and a packet length in flits. The destination follows one of three run-time patterns. Bit-complement inverts each source coordinate. Transpose swaps X and Y. Uniform random draws any other node of the mesh.

The offer decision compares an 8-bit pseudo-random sample with a programmable threshold, so the threshold sets the injection rate in steps of 1/256. The sample comes from a linear feedback shift register. A second register of the same kind supplies the uniform destinations. Both are seeded from a per-node parameter, so a run repeats exactly after every reset. Descriptors leave over a valid/ready handshake. An offer that cannot be made because the consumer is stalling is dropped, not queued.

Top module: `mesh_traffic_gen`

## Requirements
- R1: After reset, out_valid is 0.
- R2: With cfg_pattern = 1 (bit-complement), every descriptor has out_dst_x = (MESH_X-1) - SRC_X and out_dst_y = (MESH_Y-1) - SRC_Y. This is the bitwise inversion of each coordinate.
- R3: With cfg_pattern = 2 (transpose), every descriptor has out_dst_x = SRC_Y and out_dst_y = SRC_X.
- R4: With cfg_pattern = 2, a node with SRC_X = SRC_Y never raises out_valid. A node whose swapped coordinates fall outside the mesh also never raises it. Code 3 disables injection for every node.
- R5: With cfg_pattern = 0 (uniform), every destination lies inside the mesh and differs from the source. A draw that hits the source is replaced by a fresh draw. Over many packets, most other nodes appear as destinations.
- R6: A new offer is decided only in a cycle where no descriptor is held (out_valid low, or out_valid high with out_ready high). The offer happens when the 8-bit sample is below cfg_rate. So cfg_rate = 0 never offers, and cfg_rate = r offers in about r/256 of such cycles.
- R7: While out_valid is high and out_ready is low, all descriptor fields stay stable. No new decision is made while this holds. Offers lost to back-pressure are not queued.
- R8: out_len equals cfg_len_m1 + 1, as sampled in the decision cycle. It covers 1 to MAX_LEN flits.
- R9: Reset returns both pseudo-random registers to their seed-derived values. An identical input sequence after reset gives an identical output sequence.
- R10: out_src_x and out_src_y always equal the SRC_X and SRC_Y parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pattern | input | 2 | 0 uniform, 1 bit-complement, 2 transpose, 3 off |
| cfg_rate | input | RATE_W | Injection threshold |
| cfg_len_m1 | input | $clog2(MAX_LEN) | Packet length minus one |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Consumer accepts descriptor |
| out_src_x | output | $clog2(MESH_X) | Source X |
| out_src_y | output | $clog2(MESH_Y) | Source Y |
| out_dst_x | output | $clog2(MESH_X) | Destination X |
| out_dst_y | output | $clog2(MESH_Y) | Destination Y |
| out_len | output | $clog2(MAX_LEN+1) | Packet length in flits |

## Verification
A stuck or mis-seeded rate register shows up at the ports within a few hundred cycles. The count of accepted packets drifts from the threshold's proportion, or two runs from reset diverge in their first descriptors. A wrong pattern decode or swapped coordinate is visible on the very first descriptor after a pattern change. A broken hold path shows the cycle after the stall begins, as a changed field or a dropped valid. A broken redraw shows as a descriptor addressed to the node itself.

// File: rtl/mesh_tg_pkg.sv
package mesh_tg_pkg;

   typedef enum logic [1:0] {
      PAT_UNIFORM   = 2'd0,
      PAT_BITCOMP   = 2'd1,
      PAT_TRANSPOSE = 2'd2,
      PAT_OFF       = 2'd3
   } pattern_e;

   typedef enum logic {
      ST_RUN    = 1'b0,
      ST_REDRAW = 1'b1
   } gen_state_e;

   // Galois feedback masks (right-shifting form) for maximal-length registers
   function automatic logic [31:0] lfsr_taps(input int w);
      case (w)
         8:       return 32'h0000_00B8;
         16:      return 32'h0000_B400;
         24:      return 32'h00E1_0000;
         32:      return 32'hA300_0000;
         default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/mesh_tg_lfsr.sv
module mesh_tg_lfsr
   import mesh_tg_pkg::*;
#(
   parameter int               W     = 16,
   parameter int               OUT_W = 8,
   parameter logic [W-1:0]     SEED  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [OUT_W-1:0] sample
);
   localparam logic [31:0]  TAPS_FULL = lfsr_taps(W);
   localparam logic [W-1:0] TAPS      = TAPS_FULL[W-1:0];

   if (TAPS_FULL == 32'd0) begin : g_bad_width
      $error("mesh_tg_lfsr: unsupported width %0d", W);
   end
   if (SEED == '0) begin : g_bad_seed
      $error("mesh_tg_lfsr: seed must be nonzero");
   end
   if (OUT_W > W) begin : g_bad_out
      $error("mesh_tg_lfsr: OUT_W exceeds W");
   end

   logic [W-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= SEED;
      end else if (step) begin
         q <= q[0] ? ((q >> 1) ^ TAPS) : (q >> 1);
      end
   end

   assign sample = q[OUT_W-1:0];

endmodule

// File: rtl/mesh_tg_dest.sv
module mesh_tg_dest
   import mesh_tg_pkg::*;
#(
   parameter int MESH_X = 4,
   parameter int MESH_Y = 4,
   parameter int SRC_X  = 0,
   parameter int SRC_Y  = 0,
   parameter int XW     = 2,
   parameter int YW     = 2
) (
   input  pattern_e          pattern,
   input  logic [XW+YW-1:0]  rnd,
   output logic [XW-1:0]     dst_x,
   output logic [YW-1:0]     dst_y,
   output logic              silent,
   output logic              redraw
);
   localparam logic [XW-1:0] SX = XW'(SRC_X);
   localparam logic [YW-1:0] SY = YW'(SRC_Y);

   logic [XW-1:0] tr_x;
   logic [YW-1:0] tr_y;
   logic          tr_silent;

   if (MESH_X == MESH_Y) begin : g_square
      assign tr_x      = XW'(SRC_Y);
      assign tr_y      = YW'(SRC_X);
      assign tr_silent = (SRC_X == SRC_Y);
   end else begin : g_rect
      localparam bit OUTSIDE = (SRC_Y >= MESH_X) || (SRC_X >= MESH_Y);
      assign tr_x      = OUTSIDE ? SX : XW'(SRC_Y);
      assign tr_y      = OUTSIDE ? SY : YW'(SRC_X);
      assign tr_silent = OUTSIDE || (SRC_X == SRC_Y);
   end

   always_comb begin
      dst_x  = SX;
      dst_y  = SY;
      silent = 1'b0;
      redraw = 1'b0;
      case (pattern)
         PAT_UNIFORM: begin
            dst_x  = rnd[XW-1:0];
            dst_y  = rnd[XW+YW-1:XW];
            redraw = (rnd[XW-1:0] == SX) && (rnd[XW+YW-1:XW] == SY);
         end
         PAT_BITCOMP: begin
            dst_x = ~SX;
            dst_y = ~SY;
         end
         PAT_TRANSPOSE: begin
            dst_x  = tr_x;
            dst_y  = tr_y;
            silent = tr_silent;
         end
         default: begin
            silent = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/mesh_traffic_gen.sv
module mesh_traffic_gen
   import mesh_tg_pkg::*;
#(
   parameter int                 MESH_X  = 4,
   parameter int                 MESH_Y  = 4,
   parameter int                 SRC_X   = 1,
   parameter int                 SRC_Y   = 3,
   parameter int                 LFSR_W  = 16,
   parameter logic [LFSR_W-1:0]  SEED    = 16'hACE1,
   parameter int                 RATE_W  = 8,
   parameter int                 MAX_LEN = 8,
   localparam int                XW      = $clog2(MESH_X),
   localparam int                YW      = $clog2(MESH_Y),
   localparam int                LW      = $clog2(MAX_LEN),
   localparam int                OLW     = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_pattern,
   input  logic [RATE_W-1:0] cfg_rate,
   input  logic [LW-1:0]     cfg_len_m1,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [XW-1:0]     out_src_x,
   output logic [YW-1:0]     out_src_y,
   output logic [XW-1:0]     out_dst_x,
   output logic [YW-1:0]     out_dst_y,
   output logic [OLW-1:0]    out_len
);
   localparam int HALF = LFSR_W / 2;
   localparam logic [LFSR_W-1:0] DEST_SEED = {SEED[HALF-1:0], SEED[LFSR_W-1:HALF]};

   // elaboration-time parameter checks
   if (!is_pow2(MESH_X) || MESH_X < 2) begin : g_chk_mx
      $error("MESH_X must be a power of two, at least 2");
   end
   if (!is_pow2(MESH_Y) || MESH_Y < 2) begin : g_chk_my
      $error("MESH_Y must be a power of two, at least 2");
   end
   if (SRC_X < 0 || SRC_X >= MESH_X || SRC_Y < 0 || SRC_Y >= MESH_Y) begin : g_chk_src
      $error("source coordinates outside the mesh");
   end
   if (RATE_W > LFSR_W || XW + YW > LFSR_W || (LFSR_W % 2) != 0) begin : g_chk_lfsr
      $error("LFSR_W too narrow or odd");
   end
   if (!is_pow2(MAX_LEN) || MAX_LEN < 2) begin : g_chk_len
      $error("MAX_LEN must be a power of two, at least 2");
   end

   gen_state_e        state_q;
   logic              vld_q;
   logic [XW-1:0]     dst_x_q;
   logic [YW-1:0]     dst_y_q;
   logic [OLW-1:0]    len_q;

   logic [RATE_W-1:0] rate_sample;
   logic [XW+YW-1:0]  dest_rnd;
   logic [XW-1:0]     cand_x;
   logic [YW-1:0]     cand_y;
   logic              cand_silent;
   logic              cand_redraw;
   logic              in_redraw;
   logic              free;
   logic              hit;
   pattern_e          pat_sel;

   assign in_redraw = (state_q == ST_REDRAW);
   assign free      = !in_redraw && (!vld_q || out_ready);
   assign hit       = free && (rate_sample < cfg_rate);
   assign pat_sel   = in_redraw ? PAT_UNIFORM : pattern_e'(cfg_pattern);

   mesh_tg_lfsr #(
      .W     (LFSR_W),
      .OUT_W (RATE_W),
      .SEED  (SEED)
   ) u_rate_lfsr (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (free),
      .sample (rate_sample)
   );

   mesh_tg_lfsr #(
      .W     (LFSR_W),
      .OUT_W (XW + YW),
      .SEED  (DEST_SEED)
   ) u_dest_lfsr (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (1'b1),
      .sample (dest_rnd)
   );

   mesh_tg_dest #(
      .MESH_X (MESH_X),
      .MESH_Y (MESH_Y),
      .SRC_X  (SRC_X),
      .SRC_Y  (SRC_Y),
      .XW     (XW),
      .YW     (YW)
   ) u_dest (
      .pattern (pat_sel),
      .rnd     (dest_rnd),
      .dst_x   (cand_x),
      .dst_y   (cand_y),
      .silent  (cand_silent),
      .redraw  (cand_redraw)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         vld_q   <= 1'b0;
         dst_x_q <= '0;
         dst_y_q <= '0;
         len_q   <= '0;
      end else begin
         case (state_q)
            ST_RUN: begin
               if (free) begin
                  if (hit && !cand_silent && !cand_redraw) begin
                     vld_q   <= 1'b1;
                     dst_x_q <= cand_x;
                     dst_y_q <= cand_y;
                     len_q   <= OLW'(cfg_len_m1) + OLW'(1);
                  end else if (hit && cand_redraw) begin
                     vld_q   <= 1'b0;
                     state_q <= ST_REDRAW;
                     len_q   <= OLW'(cfg_len_m1) + OLW'(1);
                  end else begin
                     vld_q   <= 1'b0;
                  end
               end
            end
            default: begin
               if (!cand_redraw) begin
                  vld_q   <= 1'b1;
                  dst_x_q <= cand_x;
                  dst_y_q <= cand_y;
                  state_q <= ST_RUN;
               end
            end
         endcase
      end
   end

   assign out_valid = vld_q;
   assign out_src_x = XW'(SRC_X);
   assign out_src_y = YW'(SRC_Y);
   assign out_dst_x = dst_x_q;
   assign out_dst_y = dst_y_q;
   assign out_len   = len_q;

endmodule

// File: rtl/mesh_traffic_gen_chk.sv
module mesh_traffic_gen_chk #(
   parameter int MESH_X  = 4,
   parameter int MESH_Y  = 4,
   parameter int RATE_W  = 8,
   parameter int MAX_LEN = 8,
   localparam int XW     = $clog2(MESH_X),
   localparam int YW     = $clog2(MESH_Y),
   localparam int OLW    = $clog2(MAX_LEN + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_valid,
   input logic              out_ready,
   input logic [XW-1:0]     out_src_x,
   input logic [YW-1:0]     out_src_y,
   input logic [XW-1:0]     out_dst_x,
   input logic [YW-1:0]     out_dst_y,
   input logic [OLW-1:0]    out_len,
   input logic [RATE_W-1:0] cfg_rate,
   input logic              in_redraw
);

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_dst_x)
                                     && $stable(out_dst_y) && $stable(out_len)));

   // R5
   no_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !((out_dst_x == out_src_x) && (out_dst_y == out_src_y)));

   // R8
   len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_len >= OLW'(1) && out_len <= OLW'(MAX_LEN)));

   // R6
   rate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && !in_redraw && cfg_rate == '0) |=> !out_valid);

   // R7
   accept_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && cfg_rate == '0) |=> !out_valid);

endmodule

bind mesh_traffic_gen mesh_traffic_gen_chk #(
   .MESH_X  (MESH_X),
   .MESH_Y  (MESH_Y),
   .RATE_W  (RATE_W),
   .MAX_LEN (MAX_LEN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_src_x (out_src_x),
   .out_src_y (out_src_y),
   .out_dst_x (out_dst_x),
   .out_dst_y (out_dst_y),
   .out_len   (out_len),
   .cfg_rate  (cfg_rate),
   .in_redraw (in_redraw)
);

// File: tb/mesh_traffic_gen_bench.sv
module mesh_traffic_gen_bench;
   localparam int MX = 4;
   localparam int MY = 4;
   localparam int SX = 1;
   localparam int SY = 3;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] pat;
   logic [7:0] rate;
   logic [2:0] lenm1;
   logic       rdy;

   logic       vld, dvld;
   logic [1:0] sx, sy, dx, dy, dsx, dsy, ddx, ddy;
   logic [3:0] len, dlen;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   mesh_traffic_gen u_mesh_traffic_gen (
      .clk(clk), .rst_n(rst_n), .cfg_pattern(pat), .cfg_rate(rate),
      .cfg_len_m1(lenm1), .out_valid(vld), .out_ready(rdy),
      .out_src_x(sx), .out_src_y(sy), .out_dst_x(dx), .out_dst_y(dy), .out_len(len));

   // node on the diagonal
   mesh_traffic_gen #(.SRC_X(2), .SRC_Y(2), .SEED(16'h1D2B)) u_mesh_traffic_gen_diag (
      .clk(clk), .rst_n(rst_n), .cfg_pattern(pat), .cfg_rate(rate),
      .cfg_len_m1(lenm1), .out_valid(dvld), .out_ready(rdy),
      .out_src_x(dsx), .out_src_y(dsy), .out_dst_x(ddx), .out_dst_y(ddy), .out_len(dlen));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_dx(input int p);
      return (p == 1) ? (MX - 1 - SX) : SY;
   endfunction
   function automatic int exp_dy(input int p);
      return (p == 1) ? (MY - 1 - SY) : SX;
   endfunction

   bit         seen [16];
   logic [4:0] sig_a [300];
   logic [4:0] sig_b [300];
   int         accepts;

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic drain();
      rate = 8'd0;
      rdy  = 1'b1;
      repeat (30) @(negedge clk);
   endtask

   // mode: 0 random ready, 1 always, 2 never, 3 periodic; rec: 0 none, 1 sig_a, 2 sig_b
   task automatic run_phase(input int ncyc, input int mode, input int rec);
      bit         hold = 1'b0;
      logic [1:0] px = '0, py = '0;
      logic [3:0] pl = '0;
      accepts = 0;
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         if (hold) begin
            chk(vld == 1'b1, "R7 valid held", int'(vld), 1);
            chk(dx == px && dy == py && len == pl, "R7 fields stable",
                int'({dx, dy, len}), int'({px, py, pl}));
         end
         if (vld) begin
            chk(sx == SX && sy == SY, "R10 source", int'({sx, sy}), SX * 4 + SY);
            chk(len == 4'(lenm1) + 4'd1, "R8 length", int'(len), int'(lenm1) + 1);
            if (pat == 2'd1)
               chk(dx == exp_dx(1) && dy == exp_dy(1), "R2 bit-complement dest",
                   int'(dx) * 4 + int'(dy), exp_dx(1) * 4 + exp_dy(1));
            if (pat == 2'd2)
               chk(dx == exp_dx(2) && dy == exp_dy(2), "R3 transpose dest",
                   int'(dx) * 4 + int'(dy), exp_dx(2) * 4 + exp_dy(2));
            if (pat == 2'd0) begin
               chk(!(dx == SX && dy == SY), "R5 uniform not self",
                   int'(dx) * 4 + int'(dy), -1);
               seen[int'(dx) * 4 + int'(dy)] = 1'b1;
            end
            if (pat == 2'd3)
               chk(1'b0, "R4 code 3 offered", 1, 0);
         end
         if (pat == 2'd2 || pat == 2'd3)
            chk(dvld == 1'b0, "R4 diagonal node silent", int'(dvld), 0);
         if (rec == 1) sig_a[i] = {vld, dx, dy};
         if (rec == 2) sig_b[i] = {vld, dx, dy};
         case (mode)
            0:       rdy = 1'($urandom % 2);
            1:       rdy = 1'b1;
            2:       rdy = 1'b0;
            default: rdy = (i % 3) != 0;
         endcase
         hold = vld && !rdy;
         px = dx; py = dy; pl = len;
         if (vld && rdy) accepts++;
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      pat = 2'd0; rate = 8'd0; lenm1 = 3'd0; rdy = 1'b0;
      do_reset();

      // R1 reset state
      @(negedge clk);
      chk(vld == 1'b0, "R1 reset valid", int'(vld), 0);
      chk(dvld == 1'b0, "R1 reset valid diag", int'(dvld), 0);
      run_phase(20, 1, 0);
      chk(accepts == 0, "R6 zero rate", accepts, 0);

      // R2 bit-complement under random back-pressure
      pat = 2'd1; lenm1 = 3'd5; rate = 8'd200;
      run_phase(400, 0, 0);
      chk(accepts > 100, "R2 traffic present", accepts, 150);
      drain();

      // R3, R4 transpose with max length
      pat = 2'd2; lenm1 = 3'd7; rate = 8'd255;
      run_phase(400, 0, 0);
      chk(accepts > 100, "R3 traffic present", accepts, 200);
      drain();

      // R5 uniform, length 1
      pat = 2'd0; lenm1 = 3'd0; rate = 8'd180;
      foreach (seen[k]) seen[k] = 1'b0;
      run_phase(600, 0, 0);
      begin
         int cnt = 0;
         foreach (seen[k]) if (seen[k]) cnt++;
         chk(cnt >= 12, "R5 destination spread", cnt, 15);
         chk(!seen[SX * 4 + SY], "R5 source never hit", int'(seen[SX * 4 + SY]), 0);
      end
      drain();

      // R4 code 3
      pat = 2'd3; rate = 8'd255;
      run_phase(100, 1, 0);
      chk(accepts == 0, "R4 code 3 silent", accepts, 0);
      drain();

      // R6 rate proportion
      pat = 2'd1; lenm1 = 3'd2; rate = 8'd64;
      run_phase(4096, 1, 0);
      chk(accepts >= 850 && accepts <= 1200, "R6 rate 64/256", accepts, 1024);
      rate = 8'd255;
      run_phase(1024, 1, 0);
      chk(accepts >= 990, "R6 rate 255/256", accepts, 1020);
      drain();

      // R7 no queueing of lost offers
      rate = 8'd255; rdy = 1'b0;
      for (int i = 0; i < 20 && !vld; i++) @(negedge clk);
      chk(vld == 1'b1, "R7 offer appears", int'(vld), 1);
      rate = 8'd0;
      run_phase(50, 2, 0);
      run_phase(20, 1, 0);
      chk(accepts == 1, "R7 single accept after stall", accepts, 1);

      // R9 repeatability from reset
      pat = 2'd0; rate = 8'd150; lenm1 = 3'd2; rdy = 1'b0;
      do_reset();
      run_phase(300, 3, 1);
      rdy = 1'b0;
      do_reset();
      run_phase(300, 3, 2);
      begin
         int diff = 0;
         for (int i = 0; i < 300; i++) if (sig_a[i] !== sig_b[i]) diff++;
         chk(diff == 0, "R9 repeat after reset", diff, 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule